// File: doc/BRIEF.md
# Strided Block Address Generator

This block generates the address sequence for one side of a DMA transfer, either the read side or the write side. A 32-bit control word selects the element size, the way the address moves, a block length in elements and a stride in bytes. A start pulse captures the control word, a start address and an element count. The block then presents one address per element on a valid/ready handshake and advances only when an address is accepted.

Elements are issued in blocks. Within a block the address moves by one element size per element. When a block is complete, the next block begins at the previous block's start address, offset by the stride. A block length of zero turns the walk into one contiguous run. The final element of the programmed count carries a last flag. After that element is accepted the block returns to idle and waits for the next start.

Top module: `stride_addr_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after reset, `addr_valid`, `last` and `burst` are 0.
- R2: Control bits 31:30 select the element size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. Movement code 0 in bits 29:28 (increment) raises the address by the element size on each accepted element.
- R3: Movement code 1 (decrement) lowers the address by the element size on each accepted element, and lowers each block start by the stride.
- R4: Movement code 2 (fixed) presents the start address for every element of the transfer, across block boundaries too.
- R5: Movement code 3 (burst) walks like increment but presents the address rounded down to a multiple of the element size, with `burst` high on every element. In every other mode `burst` is 0.
- R6: Control bits 27:14 hold the block length in elements and bits 13:0 hold the stride in bytes. After block-length elements have been accepted, the next address is the previous block's start plus the stride, in the direction of movement.
- R7: A block length of 0 gives one contiguous run of the whole count, and the stride has no effect.
- R8: `last` is high with the final element of the count and with no other element. After that element is accepted, `addr_valid` is 0 in the next cycle.
- R9: While `addr_valid` is high and `addr_ready` is low, `addr`, `last` and `burst` hold their values.
- R10: A start with a count of 0 is ignored, so `addr_valid` stays 0. A start while a transfer is in progress is ignored, and the running sequence continues unchanged.
- R11: A start accepted at a clock edge gives `addr_valid` high with the first address in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| start_addr | input | AW | Byte address of the first element |
| elem_count | input | CW | Number of elements to issue |
| ctrl_word | input | 32 | Size, movement, block length and stride |
| addr_valid | output | 1 | An address is presented |
| addr_ready | input | 1 | The consumer accepts the presented address |
| addr | output | AW | Current element address |
| last | output | 1 | The presented element is the final one |
| burst | output | 1 | Burst movement is in effect |

## Verification
The assertions assume that `start_addr`, `elem_count` and `ctrl_word` matter only in the cycle where a start is accepted. They also assume that `addr_ready` may change freely, and that reset is applied before any start. The stimulus drives every input on the falling clock edge. It changes the configuration only together with a start pulse, and it includes deliberate stalls and a mid-transfer start to exercise the hold and ignore rules. Expected addresses come from a closed-form index model in the bench: block number and offset are computed from the element index and kept separate from any stepping logic.

// File: rtl/stride_addr_gen_pkg.sv
package stride_addr_gen_pkg;

    localparam int CTRL_W = 32;
    localparam int BLK_W  = 14;
    localparam int STR_W  = 14;

    typedef enum logic [1:0] {
        MV_INC   = 2'd0,
        MV_DEC   = 2'd1,
        MV_FIXED = 2'd2,
        MV_BURST = 2'd3
    } move_e;

    typedef struct packed {
        logic [1:0]       size;
        move_e            mode;
        logic [BLK_W-1:0] blk_len;
        logic [STR_W-1:0] stride;
    } walk_cfg_t;

    function automatic walk_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
        walk_cfg_t c;
        c.size    = w[31:30];
        c.mode    = move_e'(w[29:28]);
        c.blk_len = w[27:14];
        c.stride  = w[13:0];
        return c;
    endfunction

    function automatic logic [3:0] elem_bytes(input logic [1:0] size);
        return 4'd1 << size;
    endfunction

endpackage

// File: rtl/sag_count.sv
module sag_count
    import stride_addr_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CW-1:0]    count,
    input  logic             adv,
    input  logic [BLK_W-1:0] blk_len,
    output logic             is_last,
    output logic             blk_end
);

    logic [CW-1:0]    rem_q;
    logic [BLK_W-1:0] bcnt_q;

    assign is_last = (rem_q == CW'(1));
    assign blk_end = (blk_len != '0) && (bcnt_q == blk_len - BLK_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            rem_q  <= count;
            bcnt_q <= '0;
        end else if (adv) begin
            rem_q  <= rem_q - CW'(1);
            bcnt_q <= blk_end ? '0 : bcnt_q + BLK_W'(1);
        end
    end

endmodule

// File: rtl/sag_step.sv
module sag_step
    import stride_addr_gen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] bstart,
    input  walk_cfg_t     cfg,
    input  logic          blk_end,
    output logic [AW-1:0] nxt_cur,
    output logic [AW-1:0] nxt_bstart
);

    logic [AW-1:0] esz;
    logic [AW-1:0] strd;

    assign esz  = AW'(elem_bytes(cfg.size));
    assign strd = AW'(cfg.stride);

    always_comb begin
        nxt_cur    = cur;
        nxt_bstart = bstart;
        unique case (cfg.mode)
            MV_INC, MV_BURST: begin
                if (blk_end) begin
                    nxt_bstart = bstart + strd;
                    nxt_cur    = bstart + strd;
                end else begin
                    nxt_cur = cur + esz;
                end
            end
            MV_DEC: begin
                if (blk_end) begin
                    nxt_bstart = bstart - strd;
                    nxt_cur    = bstart - strd;
                end else begin
                    nxt_cur = cur - esz;
                end
            end
            default: begin
                nxt_cur    = cur;
                nxt_bstart = bstart;
            end
        endcase
    end

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
    import stride_addr_gen_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [CW-1:0]     elem_count,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [AW-1:0]     addr,
    output logic              last,
    output logic              burst
);

    logic          active_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] bstart_q;
    walk_cfg_t     cfg_q;

    logic          load;
    logic          adv;
    logic          is_last;
    logic          blk_end;
    logic [AW-1:0] nxt_cur;
    logic [AW-1:0] nxt_bstart;
    logic [AW-1:0] align_mask;

    assign load = start && !active_q && (elem_count != '0);
    assign adv  = active_q && addr_ready;

    sag_count #(.CW(CW)) u_count (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .count   (elem_count),
        .adv     (adv),
        .blk_len (cfg_q.blk_len),
        .is_last (is_last),
        .blk_end (blk_end)
    );

    sag_step #(.AW(AW)) u_step (
        .cur        (cur_q),
        .bstart     (bstart_q),
        .cfg        (cfg_q),
        .blk_end    (blk_end),
        .nxt_cur    (nxt_cur),
        .nxt_bstart (nxt_bstart)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            bstart_q <= '0;
            cfg_q    <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            cur_q    <= start_addr;
            bstart_q <= start_addr;
            cfg_q    <= decode_ctrl(ctrl_word);
        end else if (adv) begin
            if (is_last) begin
                active_q <= 1'b0;
            end else begin
                cur_q    <= nxt_cur;
                bstart_q <= nxt_bstart;
            end
        end
    end

    assign align_mask = ~(AW'(elem_bytes(cfg_q.size)) - AW'(1));
    assign addr_valid = active_q;
    assign addr       = (cfg_q.mode == MV_BURST) ? (cur_q & align_mask) : cur_q;
    assign last       = active_q && is_last;
    assign burst      = active_q && (cfg_q.mode == MV_BURST);

endmodule

// File: rtl/stride_addr_gen_chk.sv
module stride_addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          addr_valid,
    input logic          addr_ready,
    input logic [AW-1:0] addr,
    input logic          last,
    input logic          burst,
    input logic [1:0]    mode,
    input logic [1:0]    size
);

    logic [AW-1:0] low_mask;
    assign low_mask = (AW'(1) << size) - AW'(1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!addr_valid && !last && !burst));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready) |=>
            (addr_valid && $stable(addr) && $stable(last) && $stable(burst)));

    // R8
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && last) |=> !addr_valid);

    // R4
    fixed_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && !last && mode == 2'd2) |=> $stable(addr));

    // R5
    burst_align_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && burst) |-> ((addr & low_mask) == '0));

    // R5
    burst_mode_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (burst == (mode == 2'd3)));

endmodule

bind stride_addr_gen stride_addr_gen_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr       (addr),
    .last       (last),
    .burst      (burst),
    .mode       (cfg_q.mode),
    .size       (cfg_q.size)
);

// File: tb/stride_addr_gen_test.sv
module stride_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] elem_count = '0;
    logic [31:0] ctrl_word = '0;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] addr;
    logic        last;
    logic        burst;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stride_addr_gen uut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .elem_count (elem_count),
        .ctrl_word  (ctrl_word),
        .addr_valid (addr_valid),
        .addr_ready (addr_ready),
        .addr       (addr),
        .last       (last),
        .burst      (burst)
    );

    function automatic logic [31:0] mk_ctrl(input int sz, input int mv, input int bl, input int st);
        return {sz[1:0], mv[1:0], bl[13:0], st[13:0]};
    endfunction

    // {ctrl, start address, count}
    localparam logic [95:0] VEC [6] = '{
        {2'd2, 2'd0, 14'd0, 14'd0,     32'h0000_1000, 32'd5},  // R2 R7 inc 4B contiguous
        {2'd1, 2'd1, 14'd3, 14'h40,    32'h0000_2000, 32'd7},  // R3 R6 dec 2B blocks of 3
        {2'd0, 2'd2, 14'd2, 14'h10,    32'h0000_3003, 32'd4},  // R4 fixed
        {2'd3, 2'd3, 14'd0, 14'h0,     32'h0000_4005, 32'd4},  // R5 burst 8B
        {2'd2, 2'd0, 14'd2, 14'h100,   32'h0000_5000, 32'd5},  // R6 inc 4B blocks of 2
        {2'd0, 2'd3, 14'd3, 14'h20,    32'h0000_6001, 32'd6}   // R5 R6 burst 1B blocks
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr(input logic [31:0] ctrl, input logic [31:0] base,
                                               input int idx);
        int sz = int'(ctrl[31:30]);
        int mv = int'(ctrl[29:28]);
        int bl = int'(ctrl[27:14]);
        logic [31:0] st = {18'd0, ctrl[13:0]};
        logic [31:0] es = 32'd1 << sz;
        int blk = (bl == 0) ? 0 : idx / bl;
        int off = (bl == 0) ? idx : idx % bl;
        logic [31:0] a;
        case (mv)
            0:       a = base + st * blk + es * off;
            1:       a = base - st * blk - es * off;
            2:       a = base;
            default: a = (base + st * blk + es * off) & ~(es - 32'd1);
        endcase
        return a;
    endfunction

    task automatic kick(input logic [31:0] c, input logic [31:0] a, input logic [15:0] n);
        start      = 1'b1;
        ctrl_word  = c;
        start_addr = a;
        elem_count = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input logic [31:0] c, input logic [31:0] a, input int n);
        kick(c, a, n[15:0]);
        chk("R11 valid after start", {31'd0, addr_valid}, 32'd1);
        for (int i = 0; i < n; i++) begin
            chk("R2 R3 R4 R5 R6 R7 addr", addr, model_addr(c, a, i));
            chk("R8 last", {31'd0, last}, {31'd0, (i == n - 1)});
            chk("R5 burst flag", {31'd0, burst}, {31'd0, (c[29:28] == 2'd3)});
            addr_ready = 1'b1;
            @(negedge clk);
            addr_ready = 1'b0;
        end
        chk("R8 idle after last", {31'd0, addr_valid}, 32'd0);
    endtask

    initial begin
        begin : wd
            #(5ns * 20000);
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, addr_valid}, 32'd0);
        chk("R1 last in reset", {31'd0, last}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, addr_valid}, 32'd0);
        chk("R1 burst after reset", {31'd0, burst}, 32'd0);

        for (int v = 0; v < 6; v++) begin
            run_vec(VEC[v][95:64], VEC[v][63:32], int'(VEC[v][31:0]));
        end

        // R10: zero count ignored
        kick(mk_ctrl(2, 0, 0, 0), 32'h7000, 16'd0);
        chk("R10 zero count ignored", {31'd0, addr_valid}, 32'd0);

        // R9: stall holds address; R10: restart while busy ignored
        kick(mk_ctrl(1, 0, 0, 0), 32'h8000, 16'd3);
        chk("R11 first addr", addr, 32'h8000);
        addr_ready = 1'b1;
        @(negedge clk);
        addr_ready = 1'b0;
        chk("R2 second addr", addr, 32'h8002);
        @(negedge clk);
        @(negedge clk);
        chk("R9 held during stall", addr, 32'h8002);
        chk("R9 last held low", {31'd0, last}, 32'd0);
        kick(mk_ctrl(0, 1, 0, 0), 32'h9999, 16'd9);
        chk("R10 busy start ignored addr", addr, 32'h8002);
        addr_ready = 1'b1;
        @(negedge clk);
        addr_ready = 1'b0;
        chk("R10 sequence continues", addr, 32'h8004);
        chk("R8 last on third", {31'd0, last}, 32'd1);
        addr_ready = 1'b1;
        @(negedge clk);
        addr_ready = 1'b0;
        chk("R8 idle after busy-start test", {31'd0, addr_valid}, 32'd0);

        // R1: reset mid-transfer
        kick(mk_ctrl(2, 0, 0, 0), 32'hA000, 16'd4);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset aborts", {31'd0, addr_valid}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule